// File: doc/BRIEF.md
# Periodic Interrupt Waveform Generator

This block drives the active-low interrupt line of a real-time clock. A 3-bit select field picks one of eight behaviours. Two settings are static: off, with the line high, and permanently asserted, with the line low. Two are free-running square waves at 2 Hz and 1 Hz with 50% duty. Both waves are phase-locked to the second-counter increment. The remaining four are latched level interrupts. These fire on a new second, a new minute, a new hour or the start of a new month, and keep the line low until software clears the flag.

The surrounding clock supplies several inputs. The first is a one-cycle second-increment strobe. The second is a quarter-second strobe that marks the three intermediate quarter points of each second. The third is a strobe raised when software rewrites the second counter. The calendar counters also supply four boundary qualifiers, which are valid together with the increment strobe: seconds become 00, minutes become 00, hours become 00, and the day becomes 1. Software clears a latched level interrupt by pulsing `flag_clr`. The block reports its state on `flag` and drives `irq_n`.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, and whenever `mode_sel` is 000, `irq_n` is 1 and `flag` is 0.
- R2: With `mode_sel` 001, `irq_n` is 0 on every cycle and `flag` is 0.
- R3: With `mode_sel` 010, the line is low in quarters 0 and 2 of each second and high in quarters 1 and 3. Quarter 0 begins at an increment, and each `q_tick` advances one quarter.
- R4: With `mode_sel` 011, the line is low in quarters 0 and 1 of each second and high in quarters 2 and 3.
- R5: A `sec_inc` or a `sec_rewrite` returns the pulse phase to quarter 0 at the next clock edge. Either strobe takes priority over `q_tick`.
- R6: With `mode_sel` 100, every `sec_inc` sets the flag. From the next cycle, `irq_n` is 0 and `flag` is 1.
- R7: With `mode_sel` 101, the flag is set only by `sec_inc` together with `to_sec0`.
- R8: With `mode_sel` 110, the flag is set only by `sec_inc` with both `to_sec0` and `to_min0`.
- R9: With `mode_sel` 111, the flag is set only by `sec_inc` with `to_sec0`, `to_min0`, `to_hour0` and `to_day1`.
- R10: In the level modes (`mode_sel[2]` = 1), a set flag holds `irq_n` low until `flag_clr`, which then returns the line high. If an event and a clear arrive in the same cycle, the event wins.
- R11: In the pulse modes (010, 011), `flag` equals the inverse of `irq_n`, and `flag_clr` has no effect on the waveform.
- R12: While `mode_sel` is 000 or any non-level setting, a pending level flag is discarded. Returning to a level mode without an event leaves `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Waveform select |
| sec_inc | input | 1 | Second-counter increment strobe |
| q_tick | input | 1 | Quarter-second point strobe |
| sec_rewrite | input | 1 | Second counter was rewritten |
| to_sec0 | input | 1 | Increment makes seconds 00 |
| to_min0 | input | 1 | Minutes are 00 at this increment |
| to_hour0 | input | 1 | Hours are 00 at this increment |
| to_day1 | input | 1 | Day is 1 at this increment |
| flag_clr | input | 1 | Software writes the flag to 0 |
| flag | output | 1 | Interrupt flag state |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The block has two pieces of state: the quarter phase counter and the level flag. A wrong phase value shows on `irq_n` in the very cycle after the strobe that should have set it. In 2 Hz mode it inverts the wave within one quarter, and in 1 Hz mode within two quarters. A wrong level flag shows at once on both `flag` and `irq_n`, in the cycle after an event, a clear or a mode change. For that reason the scoreboard compares both outputs after every clock edge rather than only at waveform transitions.

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int PH_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       sec_inc,
  input  logic       q_tick,
  input  logic       sec_rewrite,
  input  logic       to_sec0,
  input  logic       to_min0,
  input  logic       to_hour0,
  input  logic       to_day1,
  input  logic       flag_clr,
  output logic       flag,
  output logic       irq_n
);
  localparam logic [2:0] M_OFF  = 3'b000;
  localparam logic [2:0] M_LOW  = 3'b001;
  localparam logic [2:0] M_2HZ  = 3'b010;
  localparam logic [2:0] M_1HZ  = 3'b011;
  localparam logic [2:0] M_SEC  = 3'b100;
  localparam logic [2:0] M_MIN  = 3'b101;
  localparam logic [2:0] M_HOUR = 3'b110;
  localparam logic [2:0] M_MON  = 3'b111;

  logic [PH_W-1:0] qph;
  logic            lvl_flag;
  logic            lvl_mode;
  logic            evt;
  logic            pulse_low;

  assign lvl_mode = mode_sel[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    qph <= '0;
    else if (sec_inc || sec_rewrite) qph <= '0;
    else if (q_tick)               qph <= qph + 1'b1;

  always_comb begin
    evt = 1'b0;
    unique case (mode_sel)
      M_SEC:   evt = sec_inc;
      M_MIN:   evt = sec_inc && to_sec0;
      M_HOUR:  evt = sec_inc && to_sec0 && to_min0;
      M_MON:   evt = sec_inc && to_sec0 && to_min0 && to_hour0 && to_day1;
      default: evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         lvl_flag <= 1'b0;
    else if (!lvl_mode) lvl_flag <= 1'b0;
    else if (evt)       lvl_flag <= 1'b1;
    else if (flag_clr)  lvl_flag <= 1'b0;

  assign pulse_low = (mode_sel == M_2HZ) ? !qph[0] :
                     (mode_sel == M_1HZ) ? !qph[1] : 1'b0;

  assign flag  = lvl_mode ? lvl_flag : pulse_low;
  assign irq_n = !((mode_sel == M_LOW) || pulse_low || (lvl_mode && lvl_flag));

  AST_SEC_EVENT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_SEC && sec_inc) |=> (!mode_sel[2] || (flag && !irq_n))); // R6
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[2] && flag && !flag_clr) |=> (!mode_sel[2] || flag)); // R10
  AST_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[2] && flag_clr && !sec_inc) |=> (!mode_sel[2] || irq_n)); // R10
  AST_OFF_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_OFF) |=> (!mode_sel[2] || !flag)); // R12
  AST_REWRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rewrite && mode_sel[2:1] == 2'b01) |=> (mode_sel[2:1] != 2'b01 || !irq_n)); // R5
  AST_MIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_MIN && !flag && !(sec_inc && to_sec0)) |=> (mode_sel != M_MIN || !flag)); // R7
endmodule

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       sec_inc = 0, q_tick = 0, sec_rewrite = 0;
  logic       to_sec0 = 0, to_min0 = 0, to_hour0 = 0, to_day1 = 0, flag_clr = 0;
  logic       flag, irq_n;

  localparam logic [7:0] SI = 8'h80, QT = 8'h40, RW = 8'h20, S0 = 8'h10;
  localparam logic [7:0] M0 = 8'h08, H0 = 8'h04, D1 = 8'h02, CL = 8'h01, NO = 8'h00;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string      req_q[$];

  always #2 clk = ~clk;

  periodic_irq_gen i_periodic_irq_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sec_inc(sec_inc), .q_tick(q_tick),
    .sec_rewrite(sec_rewrite), .to_sec0(to_sec0), .to_min0(to_min0), .to_hour0(to_hour0),
    .to_day1(to_day1), .flag_clr(flag_clr), .flag(flag), .irq_n(irq_n)
  );

  task automatic tick(input logic [2:0] m, input logic [7:0] s,
                      input bit e_irqn, input bit e_flag, input string r);
    @(negedge clk);
    mode_sel = m;
    {sec_inc, q_tick, sec_rewrite, to_sec0, to_min0, to_hour0, to_day1, flag_clr} = s;
    exp_q.push_back({e_irqn, e_flag});
    req_q.push_back(r);
    @(posedge clk);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if ({irq_n, flag} !== e) begin
        failures++;
        $display("FAIL %s: irq_n/flag actual=%b%b expected=%b%b", r, irq_n, flag, e[1], e[0]);
      end
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1 reset state
    if (irq_n !== 1'b1 || flag !== 1'b0) begin
      failures++;
      $display("FAIL R1: reset irq_n/flag actual=%b%b expected=10", irq_n, flag);
    end
    rst_n = 1'b1;
    tick(3'b000, NO, 1, 0, "R1");
    tick(3'b000, SI, 1, 0, "R1");
    tick(3'b001, NO, 0, 0, "R2");
    tick(3'b001, SI|QT, 0, 0, "R2");
    // R3 2 Hz wave
    tick(3'b010, SI, 0, 1, "R3");
    tick(3'b010, QT, 1, 0, "R3");
    tick(3'b010, QT, 0, 1, "R3");
    tick(3'b010, QT, 1, 0, "R3");
    tick(3'b010, SI, 0, 1, "R5");
    tick(3'b010, CL, 0, 1, "R11");
    tick(3'b010, SI|QT, 0, 1, "R5");
    // R4 1 Hz wave
    tick(3'b011, SI, 0, 1, "R4");
    tick(3'b011, QT|CL, 0, 1, "R11");
    tick(3'b011, QT, 1, 0, "R4");
    tick(3'b011, QT, 1, 0, "R4");
    tick(3'b011, RW, 0, 1, "R5");
    tick(3'b011, QT, 0, 1, "R4");
    tick(3'b011, QT, 1, 0, "R4");
    tick(3'b011, RW|QT, 0, 1, "R5");
    // R6 per second, R10 hold and clear
    tick(3'b100, NO, 1, 0, "R6");
    tick(3'b100, QT, 1, 0, "R6");
    tick(3'b100, SI, 0, 1, "R6");
    tick(3'b100, NO, 0, 1, "R10");
    tick(3'b100, CL, 1, 0, "R10");
    tick(3'b100, SI|CL, 0, 1, "R10");
    tick(3'b100, CL, 1, 0, "R10");
    // R7 per minute
    tick(3'b101, SI, 1, 0, "R7");
    tick(3'b101, S0, 1, 0, "R7");
    tick(3'b101, SI|S0, 0, 1, "R7");
    tick(3'b101, CL, 1, 0, "R10");
    // R8 per hour
    tick(3'b110, SI|S0, 1, 0, "R8");
    tick(3'b110, SI|M0, 1, 0, "R8");
    tick(3'b110, SI|S0|M0, 0, 1, "R8");
    tick(3'b110, CL, 1, 0, "R10");
    // R9 per month
    tick(3'b111, SI|S0|M0|H0, 1, 0, "R9");
    tick(3'b111, SI|S0|M0|D1, 1, 0, "R9");
    tick(3'b111, SI|S0|M0|H0|D1, 0, 1, "R9");
    // R12 off discards pending flag
    tick(3'b000, NO, 1, 0, "R12");
    tick(3'b111, NO, 1, 0, "R12");
    tick(3'b100, SI, 0, 1, "R6");
    tick(3'b010, NO, 0, 1, "R11");
    tick(3'b100, NO, 1, 0, "R12");
    @(negedge clk);
    {sec_inc, q_tick, sec_rewrite, to_sec0, to_min0, to_hour0, to_day1, flag_clr} = '0;
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule